// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the per-channel control register file of a multi-channel descriptor DMA engine. A host reaches it over a simple 32-bit register bus. Each bus address carries a channel index and a register offset. The block splits the address into those two parts, answers reads and writes one cycle after the request, and flags bad accesses with an error response.

Each channel keeps five descriptor pointer registers, a command register, a configuration register, an interrupt mask and a stream command register. It also tracks a one-hot channel state. Writes to the configuration register and recognised stream commands move that state between reset, stopped and running. Interrupt events from the engine collect in a sticky raw register. The host clears them through a write-one-to-clear acknowledge register. A channel raises its interrupt line whenever the raw bits ANDed with the mask are nonzero.

Writes to the command and stream command registers produce one-cycle strobes that tell the descriptor walker to continue or to act on a stream command. Memory traffic and the walk over descriptors belong to the engine and are not part of this block.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel index is taken from address bit 13 upward, and the register offset is address bits [7:0]. Address bits [12:8] are ignored, so they alias. Every request, accepted or not, is answered with `bus_rvalid` high in the following cycle. Write responses return `bus_rdata` = 0.
- R2: A request with `bus_be` other than 4'b1111, or with a channel index of NCH or more, gets `bus_err` = 1 and `bus_rdata` = 0. It changes no state and raises no strobe.
- R3: The pointer registers at offsets 0x00, 0x58, 0x5C, 0x60 and 0x7C each hold a full 32-bit word. They read back the last value written and reset to 0.
- R4: The configuration register at 0x84 keeps bits [1:0]: bit 0 is enable and bit 1 is stop. A write with bit 0 clear sets the state to reset (3'b001). A write with bits 0 and 1 both set sets the state to stopped (3'b010). A write with only bit 0 set leaves the state unchanged. `run_state` is always one-hot.
- R5: The status word at 0x88 is read-only, and writes to it have no effect. Bits [2:0] hold the state, bit 5 holds `eol_flag`, bits [8 +: SW] hold `src_code`, and all other bits are 0. After reset, with `src_code` = 1 and `eol_flag` = 0, it reads 0x101.
- R6: The raw interrupt register at 0x94 (low IW bits) is read-only. It ORs in `evt_intr` every cycle, and the bits stay set. Writing the acknowledge register at 0x90 clears the raw bits that are set in the written data. An event in the same cycle as an acknowledge wins. The acknowledge register reads as 0.
- R7: The mask register at 0x8C keeps the low IW bits. The masked register at 0x98 reads raw AND mask. `irq[ch]` is high exactly when that value is nonzero, from the cycle after the write or event that changed it.
- R8: A write to the command register at 0x80 stores bit 0. It pulses `cont_pulse[ch]` high for exactly the one cycle after the write.
- R9: A write to the stream command register at 0x9C stores and reads back bits [9:0]. It pulses `scmd_pulse[ch]` for one cycle, and `scmd_code` carries data bits [9:0] in that same cycle.
- R10: A stream command with bit 9 set, or with bits 8, 6 and 5 all set, puts the channel in the running state (3'b100). Any other stream command leaves the state unchanged.
- R11: Offsets that are not in the map, including offsets that are not word aligned, read as 0 without an error. Writes to them change nothing.
- R12: An access to one channel changes no register, state, strobe or interrupt of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address: channel index from bit 13, offset in [7:0] |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after a request |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Error response |
| evt_intr | input | NCH*IW | Interrupt events from the engine, IW bits per channel |
| eol_flag | input | NCH | End-of-list flag per channel, shown in status |
| src_code | input | NCH*SW | Command source code per channel, shown in status |
| irq | output | NCH | Interrupt line per channel |
| run_state | output | NCH*3 | One-hot state per channel |
| cont_pulse | output | NCH | Continue strobe per channel |
| scmd_pulse | output | NCH | Stream command strobe per channel |
| scmd_code | output | 10 | Stream command bits that go with a strobe |

## Verification
The bench targets the cases where one write does two things at once. The first is an acknowledge that lands in the same cycle as a new event: a design that lets the acknowledge win loses the event, and its interrupt line drops. The second is a configuration write with only enable set: a design that decodes the bits as a plain state code moves a running channel to reset or stopped. The third is a stream command that has load-data set but not burst: a design that tests single bits starts the channel when it should not. Sub-word, out-of-range, aliased and misaligned addresses are mixed into random traffic, because a decoder that checks only part of the address corrupts a neighbouring channel or fails to return an error.

// File: rtl/dma_chan_regs_pkg.sv
// Package: register offsets, channel state encoding and stream command
// decoding shared by the register unit and its channel slices.
package dma_chan_regs_pkg;

    localparam int OFFW = 8;     // register offset width
    localparam int NPTR = 5;     // descriptor pointer registers per channel
    localparam int CHSH = 13;    // channel window is 2**CHSH bytes
    localparam int SCW  = 10;    // meaningful stream command bits

    localparam logic [OFFW-1:0] OFF_DPTR  = 8'h00;
    localparam logic [OFFW-1:0] OFF_SDPTR = 8'h58;
    localparam logic [OFFW-1:0] OFF_SBUF  = 8'h5C;
    localparam logic [OFFW-1:0] OFF_GRP   = 8'h60;
    localparam logic [OFFW-1:0] OFF_GDOWN = 8'h7C;
    localparam logic [OFFW-1:0] OFF_CMD   = 8'h80;
    localparam logic [OFFW-1:0] OFF_CFG   = 8'h84;
    localparam logic [OFFW-1:0] OFF_STAT  = 8'h88;
    localparam logic [OFFW-1:0] OFF_MASK  = 8'h8C;
    localparam logic [OFFW-1:0] OFF_ACK   = 8'h90;
    localparam logic [OFFW-1:0] OFF_RAW   = 8'h94;
    localparam logic [OFFW-1:0] OFF_MSKD  = 8'h98;
    localparam logic [OFFW-1:0] OFF_SCMD  = 8'h9C;

    typedef enum logic [2:0] {
        ST_RESET = 3'b001,
        ST_STOP  = 3'b010,
        ST_RUN   = 3'b100
    } chan_state_e;

    // Offset of pointer register number idx.
    function automatic logic [OFFW-1:0] ptr_offset(input int idx);
        case (idx)
            0:       return OFF_DPTR;
            1:       return OFF_SDPTR;
            2:       return OFF_SBUF;
            3:       return OFF_GRP;
            default: return OFF_GDOWN;
        endcase
    endfunction

    // A stream command starts the channel on a context load, or on a
    // data-descriptor load that also asks for a burst.
    function automatic logic starts_channel(input logic [SCW-1:0] c);
        return c[9] | (c[8] & c[6] & c[5]);
    endfunction

endpackage

// File: rtl/dma_chan_regs_decode.sv
// Address decoder: splits the bus address into a channel index and a
// register offset. It accepts only full-word accesses to existing channels
// and produces a one-hot channel select for accepted requests.
// Assumes AW > 13 and NCH <= 2**(AW-13).
module dma_chan_regs_decode
    import dma_chan_regs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16
) (
    input  logic             bus_valid,
    input  logic [AW-1:0]    bus_addr,
    input  logic [3:0]       bus_be,
    output logic             acc_ok,
    output logic             acc_err,
    output logic [NCH-1:0]   ch_sel,
    output logic [OFFW-1:0]  offset
);
    localparam int IDXW = AW - CHSH;

    logic [IDXW-1:0] ch_idx;
    logic            in_range;
    logic            full_word;
    logic            unused_alias;

    // Split the address into its fields.
    always_comb begin
        ch_idx       = bus_addr[AW-1:CHSH];
        offset       = bus_addr[OFFW-1:0];
        unused_alias = ^bus_addr[CHSH-1:OFFW];
    end

    // Classify the request as accepted or erroneous.
    always_comb begin
        in_range  = {1'b0, ch_idx} < (IDXW+1)'(NCH);
        full_word = (bus_be == 4'hF);
        acc_ok    = bus_valid & in_range & full_word;
        acc_err   = bus_valid & ~(in_range & full_word);
    end

    // One select line per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_sel
        assign ch_sel[g] = acc_ok & (ch_idx == IDXW'(g));
    end

endmodule

// File: rtl/dma_chan_regs_chan.sv
// One channel slice: pointer, command, configuration, mask, raw interrupt
// and stream command registers; the one-hot channel state; the interrupt
// line; and the continue and stream strobes. Assumes sel is high only for an
// accepted full-word access to this channel, and that IW <= 32, SW <= 23.
module dma_chan_regs_chan
    import dma_chan_regs_pkg::*;
#(
    parameter int IW = 4,
    parameter int SW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            wr,
    input  logic [OFFW-1:0] off,
    input  logic [31:0]     wdata,
    input  logic [IW-1:0]   evt_intr,
    input  logic            eol_flag,
    input  logic [SW-1:0]   src_code,
    output logic [31:0]     rdata,
    output logic            irq,
    output logic [2:0]      state,
    output logic            cont_pulse,
    output logic            scmd_pulse
);
    logic [31:0]     ptr_q [NPTR];
    logic            cmd_q;
    logic [1:0]      cfg_q;
    logic [IW-1:0]   mask_q;
    logic [IW-1:0]   raw_q;
    logic [SCW-1:0]  scmd_q;
    chan_state_e     state_q;
    chan_state_e     state_d;
    logic            cont_q;
    logic            scmd_pulse_q;
    logic            wr_hit;
    logic [IW-1:0]   ack_bits;
    logic [IW-1:0]   masked;

    assign wr_hit = sel & wr;

    // Pointer registers, one per map entry.
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g] <= '0;
            else if (wr_hit && off == ptr_offset(g))
                ptr_q[g] <= wdata;
        end
    end

    // Command, configuration, mask and stream command storage plus strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q        <= 1'b0;
            cfg_q        <= 2'b00;
            mask_q       <= '0;
            scmd_q       <= '0;
            cont_q       <= 1'b0;
            scmd_pulse_q <= 1'b0;
        end else begin
            cont_q       <= wr_hit && off == OFF_CMD;
            scmd_pulse_q <= wr_hit && off == OFF_SCMD;
            if (wr_hit && off == OFF_CMD)  cmd_q  <= wdata[0];
            if (wr_hit && off == OFF_CFG)  cfg_q  <= wdata[1:0];
            if (wr_hit && off == OFF_MASK) mask_q <= wdata[IW-1:0];
            if (wr_hit && off == OFF_SCMD) scmd_q <= wdata[SCW-1:0];
        end
    end

    // Bits the host acknowledges in this cycle.
    always_comb begin
        ack_bits = (wr_hit && off == OFF_ACK) ? wdata[IW-1:0] : '0;
    end

    // Sticky raw interrupts: acknowledge clears, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~ack_bits) | evt_intr;
    end

    // Next channel state from configuration writes and stream commands.
    always_comb begin
        state_d = state_q;
        if (wr_hit && off == OFF_CFG) begin
            if (!wdata[0])
                state_d = ST_RESET;
            else if (wdata[1])
                state_d = ST_STOP;
        end
        if (wr_hit && off == OFF_SCMD && starts_channel(wdata[SCW-1:0]))
            state_d = ST_RUN;
    end

    // Channel state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    // Masked interrupts and the interrupt line.
    always_comb begin
        masked = raw_q & mask_q;
        irq    = |masked;
    end

    // Read multiplexer over the channel's register map.
    always_comb begin
        rdata = '0;
        case (off)
            OFF_CMD:  rdata[0]        = cmd_q;
            OFF_CFG:  rdata[1:0]      = cfg_q;
            OFF_STAT: begin
                rdata[2:0]      = state_q;
                rdata[5]        = eol_flag;
                rdata[8 +: SW]  = src_code;
            end
            OFF_MASK: rdata[IW-1:0]   = mask_q;
            OFF_RAW:  rdata[IW-1:0]   = raw_q;
            OFF_MSKD: rdata[IW-1:0]   = masked;
            OFF_SCMD: rdata[SCW-1:0]  = scmd_q;
            default: begin
                for (int k = 0; k < NPTR; k++)
                    if (off == ptr_offset(k)) rdata = ptr_q[k];
            end
        endcase
    end

    assign state      = state_q;
    assign cont_pulse = cont_q;
    assign scmd_pulse = scmd_pulse_q;

    // R4
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R4
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_CFG && !wdata[0]) |=> state_q == ST_RESET);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_ACK && evt_intr == '0)
        |=> (raw_q & $past(wdata[IW-1:0])) == '0);

    // R8
    cont_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_CMD) |=> cont_pulse);

    // R10
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == OFF_SCMD && wdata[9]) |=> state_q == ST_RUN);

endmodule

// File: rtl/dma_chan_regs.sv
// DMA channel register and interrupt unit, top level. It decodes bus
// requests, routes them to NCH channel slices, and returns a registered
// response one cycle later. It also holds the stream command code that goes
// with the stream strobes. Assumes one request per cycle and no back-pressure.
module dma_chan_regs
    import dma_chan_regs_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int IW  = 4,
    parameter int SW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [AW-1:0]     bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic [NCH*IW-1:0] evt_intr,
    input  logic [NCH-1:0]    eol_flag,
    input  logic [NCH*SW-1:0] src_code,
    output logic [NCH-1:0]    irq,
    output logic [NCH*3-1:0]  run_state,
    output logic [NCH-1:0]    cont_pulse,
    output logic [NCH-1:0]    scmd_pulse,
    output logic [SCW-1:0]    scmd_code
);
    logic            acc_ok;
    logic            acc_err;
    logic [NCH-1:0]  ch_sel;
    logic [OFFW-1:0] offset;
    logic [31:0]     ch_rdata [NCH];
    logic [31:0]     rd_mux;
    logic            rvalid_q;
    logic            err_q;
    logic [31:0]     rdata_q;
    logic [SCW-1:0]  code_q;

    dma_chan_regs_decode #(.NCH(NCH), .AW(AW)) u_decode (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .acc_ok    (acc_ok),
        .acc_err   (acc_err),
        .ch_sel    (ch_sel),
        .offset    (offset)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan_regs_chan #(.IW(IW), .SW(SW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (ch_sel[g]),
            .wr         (bus_write),
            .off        (offset),
            .wdata      (bus_wdata),
            .evt_intr   (evt_intr[g*IW +: IW]),
            .eol_flag   (eol_flag[g]),
            .src_code   (src_code[g*SW +: SW]),
            .rdata      (ch_rdata[g]),
            .irq        (irq[g]),
            .state      (run_state[g*3 +: 3]),
            .cont_pulse (cont_pulse[g]),
            .scmd_pulse (scmd_pulse[g])
        );
    end

    // Pick the read data of the selected channel (zero when none).
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++)
            if (ch_sel[i]) rd_mux = ch_rdata[i];
    end

    // Registered bus response and stream command code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
            code_q   <= '0;
        end else begin
            rvalid_q <= bus_valid;
            err_q    <= acc_err;
            rdata_q  <= bus_write ? '0 : rd_mux;
            if (acc_ok && bus_write && offset == OFF_SCMD)
                code_q <= bus_wdata[SCW-1:0];
        end
    end

    assign bus_rvalid = rvalid_q;
    assign bus_err    = err_q;
    assign bus_rdata  = rdata_q;
    assign scmd_code  = code_q;

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_rvalid);

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_rvalid);

    // R2
    subword_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_be != 4'hF) |=> (bus_err && bus_rdata == '0));

    // R9
    scmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && bus_write && offset == OFF_SCMD)
        |=> (scmd_code == $past(bus_wdata[SCW-1:0]) && $onehot0(scmd_pulse)));

endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
// Bench for the DMA channel register unit: directed corner cases followed by
// seeded random traffic, checked against a behavioural model of the map.
module dma_chan_regs_tb;
    import dma_chan_regs_pkg::*;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int IW  = 4;
    localparam int SW  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n;
    logic              bus_valid, bus_write;
    logic [AW-1:0]     bus_addr;
    logic [3:0]        bus_be;
    logic [31:0]       bus_wdata;
    logic              bus_rvalid, bus_err;
    logic [31:0]       bus_rdata;
    logic [NCH*IW-1:0] evt_intr;
    logic [NCH-1:0]    eol_flag;
    logic [NCH*SW-1:0] src_code;
    logic [NCH-1:0]    irq, cont_pulse, scmd_pulse;
    logic [NCH*3-1:0]  run_state;
    logic [9:0]        scmd_code;

    dma_chan_regs #(.NCH(NCH), .AW(AW), .IW(IW), .SW(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .evt_intr(evt_intr), .eol_flag(eol_flag), .src_code(src_code),
        .irq(irq), .run_state(run_state), .cont_pulse(cont_pulse),
        .scmd_pulse(scmd_pulse), .scmd_code(scmd_code)
    );

    // Model state.
    logic [31:0]    m_ptr   [NCH][NPTR];
    logic           m_cmd   [NCH];
    logic [1:0]     m_cfg   [NCH];
    logic [2:0]     m_state [NCH];
    logic [IW-1:0]  m_mask  [NCH];
    logic [IW-1:0]  m_raw   [NCH];
    logic [9:0]     m_scmd  [NCH];
    logic [9:0]     m_code;
    logic [SW-1:0]  m_src   [NCH];
    logic           m_eol   [NCH];
    logic [NCH-1:0] m_cont, m_spulse;

    int n_checks = 0;
    int n_fail   = 0;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            src_code[i*SW +: SW] = m_src[i];
            eol_flag[i]          = m_eol[i];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int ptr_index(input logic [7:0] off);
        for (int k = 0; k < NPTR; k++)
            if (off == ptr_offset(k)) return k;
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(input int ch, input logic [7:0] off);
        logic [31:0] v = '0;
        int pi = ptr_index(off);
        if (pi >= 0) return m_ptr[ch][pi];
        case (off)
            OFF_CMD:  v[0] = m_cmd[ch];
            OFF_CFG:  v[1:0] = m_cfg[ch];
            OFF_STAT: begin v[2:0] = m_state[ch]; v[5] = m_eol[ch]; v[8 +: SW] = m_src[ch]; end
            OFF_MASK: v[IW-1:0] = m_mask[ch];
            OFF_RAW:  v[IW-1:0] = m_raw[ch];
            OFF_MSKD: v[IW-1:0] = m_raw[ch] & m_mask[ch];
            OFF_SCMD: v[9:0] = m_scmd[ch];
            default:  v = '0;
        endcase
        return v;
    endfunction

    task automatic model_write(input int ch, input logic [7:0] off, input logic [31:0] d);
        int pi = ptr_index(off);
        if (pi >= 0) m_ptr[ch][pi] = d;
        case (off)
            OFF_CMD:  begin m_cmd[ch] = d[0]; m_cont[ch] = 1'b1; end
            OFF_CFG:  begin
                m_cfg[ch] = d[1:0];
                if (!d[0]) m_state[ch] = 3'b001;
                else if (d[1]) m_state[ch] = 3'b010;
            end
            OFF_MASK: m_mask[ch] = d[IW-1:0];
            OFF_ACK:  m_raw[ch] = m_raw[ch] & ~d[IW-1:0];
            OFF_SCMD: begin
                m_scmd[ch] = d[9:0]; m_code = d[9:0]; m_spulse[ch] = 1'b1;
                if (d[9] || (d[8] && d[6] && d[5])) m_state[ch] = 3'b100;
            end
            default: ;
        endcase
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < NPTR; k++) m_ptr[c][k] = '0;
            m_cmd[c] = 0; m_cfg[c] = 0; m_state[c] = 3'b001;
            m_mask[c] = 0; m_raw[c] = 0; m_scmd[c] = 0;
        end
        m_code = 0; m_cont = 0; m_spulse = 0;
    endtask

    // Checks on the per-channel outputs after an edge.
    task automatic check_outputs();
        logic [NCH-1:0]   e_irq;
        logic [NCH*3-1:0] e_st;
        for (int c = 0; c < NCH; c++) begin
            e_irq[c]        = |(m_raw[c] & m_mask[c]);
            e_st[c*3 +: 3]  = m_state[c];
        end
        chk("R7 irq", 32'(irq), 32'(e_irq));
        chk("R4 run_state", 32'(run_state), 32'(e_st));
        chk("R8 cont_pulse", 32'(cont_pulse), 32'(m_cont));
        chk("R9 scmd_pulse", 32'(scmd_pulse), 32'(m_spulse));
        if (m_spulse != 0) chk("R9 scmd_code", 32'(scmd_code), 32'(m_code));
    endtask

    // One bus transaction, optionally with interrupt events in the same cycle.
    task automatic op(input logic wr, input int ch, input logic [4:0] alias_bits,
                      input logic [7:0] off, input logic [31:0] d,
                      input logic [3:0] be, input logic [NCH*IW-1:0] evt);
        logic        e_err = (be != 4'hF) || (ch >= NCH);
        logic [31:0] e_rd  = (!wr && !e_err) ? exp_read(ch, off) : 32'h0;
        logic [2:0]  chb   = 3'(ch);
        bus_valid = 1; bus_write = wr; bus_addr = {chb, alias_bits, off};
        bus_be = be; bus_wdata = d; evt_intr = evt;
        m_cont = 0; m_spulse = 0;
        @(negedge clk);
        bus_valid = 0; evt_intr = '0;
        if (wr && !e_err) model_write(ch, off, d);
        for (int c = 0; c < NCH; c++) m_raw[c] = m_raw[c] | evt[c*IW +: IW];
        chk("R1 rvalid", 32'(bus_rvalid), 32'h1);
        chk("R2 err", 32'(bus_err), 32'(e_err));
        chk(wr ? "R1 write rdata" : "R3/R11 read data", bus_rdata, e_rd);
        check_outputs();
    endtask

    task automatic idle(input logic [NCH*IW-1:0] evt);
        bus_valid = 0; evt_intr = evt; m_cont = 0; m_spulse = 0;
        @(negedge clk);
        evt_intr = '0;
        for (int c = 0; c < NCH; c++) m_raw[c] = m_raw[c] | evt[c*IW +: IW];
        chk("R1 idle rvalid", 32'(bus_rvalid), 32'h0);
        check_outputs();
    endtask

    task automatic rd(input int ch, input logic [7:0] off);
        op(1'b0, ch, 5'd0, off, 32'h0, 4'hF, '0);
    endtask

    task automatic wrr(input int ch, input logic [7:0] off, input logic [31:0] d);
        op(1'b1, ch, 5'd0, off, d, 4'hF, '0);
    endtask

    localparam logic [7:0] OFFS [16] = '{8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C,
        8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'h98, 8'h9C, 8'h04, 8'h5A, 8'hA4};

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7531));
        for (int c = 0; c < NCH; c++) begin m_src[c] = SW'(c + 1); m_eol[c] = 0; end
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_be = 4'hF;
        bus_wdata = '0; evt_intr = '0; rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R5: reset status of channel 0 reads 0x101.
        rd(0, OFF_STAT);
        chk("R5 reset status", bus_rdata, 32'h101);
        // R3: pointers reset to 0; write and read back, also via alias (R1).
        rd(2, OFF_GDOWN);
        wrr(2, OFF_SBUF, 32'hCAFE_0123);
        op(1'b0, 2, 5'h1F, OFF_SBUF, 32'h0, 4'hF, '0);
        chk("R1 aliased R3 readback", bus_rdata, 32'hCAFE_0123);
        // R12: other channel untouched.
        rd(1, OFF_SBUF);
        chk("R12 neighbour ptr", bus_rdata, 32'h0);

        // R4 / R10: state transitions.
        wrr(0, OFF_CFG, 32'h1);            // enable only: stays reset
        wrr(0, OFF_SCMD, 32'h200);         // context load: running
        chk("R10 run on 0x200", 32'(run_state[2:0]), 32'h4);
        wrr(0, OFF_CFG, 32'h1);            // enable only: stays running
        chk("R4 enable keeps run", 32'(run_state[2:0]), 32'h4);
        wrr(0, OFF_CFG, 32'h3);
        chk("R4 stop", 32'(run_state[2:0]), 32'h2);
        wrr(0, OFF_SCMD, 32'h160);
        chk("R10 run on 0x160", 32'(run_state[2:0]), 32'h4);
        wrr(0, OFF_CFG, 32'h2);            // enable clear wins over stop
        chk("R4 reset", 32'(run_state[2:0]), 32'h1);
        wrr(0, OFF_SCMD, 32'hFFFF_F540);   // load data without burst
        chk("R10 no start", 32'(run_state[2:0]), 32'h1);
        rd(0, OFF_SCMD);
        chk("R9 low bits kept", bus_rdata, 32'h140);

        // R8: continue strobe lasts one cycle.
        wrr(3, OFF_CMD, 32'h1);
        chk("R8 strobe high", 32'(cont_pulse), 32'h8);
        idle('0);
        chk("R8 strobe gone", 32'(cont_pulse), 32'h0);

        // R6 / R7: events, mask, acknowledge and same-cycle priority.
        idle({4'h0, 4'h0, 4'h5, 4'h0});
        wrr(1, OFF_MASK, 32'h4);
        chk("R7 irq on", 32'(irq), 32'h2);
        rd(1, OFF_MSKD);
        chk("R7 masked", bus_rdata, 32'h4);
        op(1'b1, 1, 5'd0, OFF_ACK, 32'hF, 4'hF, {4'h0, 4'h0, 4'h4, 4'h0});
        chk("R6 event beats ack", 32'(irq), 32'h2);
        rd(1, OFF_ACK);
        chk("R6 ack reads 0", bus_rdata, 32'h0);
        wrr(1, OFF_ACK, 32'h4);
        chk("R6 ack clears", 32'(irq), 32'h0);
        wrr(1, OFF_RAW, 32'hF);            // read-only
        rd(1, OFF_RAW);
        chk("R6 raw read-only", bus_rdata, 32'h0);

        // R2: sub-word and out-of-range accesses.
        op(1'b1, 1, 5'd0, OFF_DPTR, 32'h1234, 4'h3, '0);
        chk("R2 subword err", 32'(bus_err), 32'h1);
        rd(1, OFF_DPTR);
        chk("R2 no write effect", bus_rdata, 32'h0);
        rd(6, OFF_STAT);
        chk("R2 range err", 32'(bus_err), 32'h1);

        // R11 / R5: unmapped and status writes ignored; eol bit.
        wrr(2, 8'h5A, 32'hFFFF_FFFF);
        rd(2, 8'h5A);
        chk("R11 unmapped 0", bus_rdata, 32'h0);
        m_eol[2] = 1;
        wrr(2, OFF_STAT, 32'hFFFF_FFFF);
        rd(2, OFF_STAT);
        chk("R5 eol and src", bus_rdata, 32'h321);

        // Random traffic (all requirements).
        for (int n = 0; n < 600; n++) begin
            int ch = ($urandom % 8 < 7) ? int'($urandom % NCH) : NCH + int'($urandom % (8 - NCH));
            logic [7:0] off = OFFS[$urandom % 16];
            logic [4:0] al  = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
            logic [3:0] be  = ($urandom % 8 == 0) ? 4'($urandom % 15) : 4'hF;
            logic [NCH*IW-1:0] ev = ($urandom % 4 == 0) ? (NCH*IW)'($urandom & $urandom) : '0;
            if ($urandom % 16 == 0) m_eol[$urandom % NCH] ^= 1'b1;
            if ($urandom % 10 == 0) idle(ev);
            else op(1'($urandom), ch, al, off, $urandom, be, ev);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule